// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits on the data path of a 32-bit external memory bus and looks after one parity bit per data byte. For outgoing writes it drives a parity lane for every byte, whatever checking mode the addressed bank uses. For incoming reads it compares the received parity lanes against the read data and records which active byte lanes disagree. A single global sense input selects odd or even parity for every bank.

Each bank carries a two-bit mode: checking off, plain checking, or read-modify-write parity. In read-modify-write mode on a full-width port, a partial write is merged with the previously read word, byte by byte, and the write parity is generated over that merged word. Read-modify-write on a narrower port is a configuration mistake: it is flagged and no check is made. All error flags are registered, sticky, and cleared by write-one-to-clear strobes.

Top module: `lane_parity_unit`

## Requirements
- R1: `wr_par[i]` is the parity of byte lane i of `wr_merged` (lane i is bits 8i+7:8i), driven combinationally for every mode value, including 2'b00 and 2'b11.
- R2: With `odd_par`=0 each byte plus its parity bit holds an even number of ones; with `odd_par`=1 it holds an odd number.
- R3: With `par_mode`=2'b01, a read (`rd_valid`=1) whose parity lane i disagrees with the parity of read byte i, on an active lane, sets `lane_err[i]` on the clock edge that samples it.
- R4: `par_mode` values 2'b00 and 2'b11 make no check: no `lane_err` bit is set by a read in those modes.
- R5: A lane is active when its `rd_be` bit is set and it lies within the port: `port_size` 2'b00 (8-bit) covers lane 0, 2'b01 (16-bit) covers lanes 0 and 1, 2'b10 and 2'b11 (32-bit) cover all four lanes.
- R6: With `par_mode`=2'b10 on a 32-bit port, `wr_merged` takes byte i from `wr_data` where `wr_be[i]`=1 and from `rd_data` otherwise, and reads are checked as in R3; in every other case `wr_merged` equals `wr_data`.
- R7: With `par_mode`=2'b10 on an 8- or 16-bit port, a read sets `cfg_err` and sets no `lane_err` bit.
- R8: A set `lane_err` bit or `cfg_err` stays set until a 1 on its clear strobe (`lane_clr[i]`, `cfg_clr`); a new error in the same cycle as its clear wins.
- R9: `any_err` is 1 exactly when at least one `lane_err` bit is set.
- R10: Synchronous active-low reset clears `lane_err`, `cfg_err` and `any_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_mode | input | 2 | Bank parity mode: 00 off, 01 check, 10 read-modify-write, 11 off |
| port_size | input | 2 | 00 8-bit, 01 16-bit, 1x 32-bit |
| odd_par | input | 1 | 1 selects odd parity, 0 even |
| wr_data | input | 32 | Write data from the controller |
| wr_be | input | 4 | Write byte enables |
| rd_data | input | 32 | Read data (also the old word for merging) |
| rd_par | input | 4 | Received parity lanes |
| rd_be | input | 4 | Read byte lanes of the current transfer |
| rd_valid | input | 1 | Read data and parity are valid this cycle |
| lane_clr | input | 4 | Write-one-to-clear strobes for lane errors |
| cfg_clr | input | 1 | Write-one-to-clear strobe for the configuration error |
| wr_par | output | 4 | Parity lanes to drive |
| wr_merged | output | 32 | Write word after read-modify-write merge |
| lane_err | output | 4 | Sticky per-lane parity errors |
| cfg_err | output | 1 | Sticky read-modify-write on narrow port error |
| any_err | output | 1 | OR of all lane errors |

## Verification
The bench builds the block with its defaults, four lanes of eight bits, so every port size maps onto a distinct subset of real lanes and the 16-bit case leaves two lanes that must stay silent. With four lanes, random byte enables and random parity corruption reach every combination of active mask, lane mismatch and mode within a few hundred cycles, including the reserved mode and the reserved port size. Directed steps add same-cycle set and clear, and read-modify-write on each narrow width.

// File: rtl/lpu_pkg.sv
// Shared encodings for the byte-lane parity unit.
// Assumes the mode and port-size fields arrive as two-bit codes.
package lpu_pkg;

    typedef enum logic [1:0] {
        PM_OFF   = 2'b00,
        PM_CHECK = 2'b01,
        PM_RMW   = 2'b10,
        PM_RSVD  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        PS_8    = 2'b00,
        PS_16   = 2'b01,
        PS_32   = 2'b10,
        PS_32R  = 2'b11
    } port_size_e;

    // Number of lanes a port of the given size spans, capped at the lane count.
    function automatic int unsigned lanes_in_port(input port_size_e ps, input int unsigned n_lanes);
        int unsigned n;
        case (ps)
            PS_8:    n = 1;
            PS_16:   n = 2;
            default: n = n_lanes;
        endcase
        return (n > n_lanes) ? n_lanes : n;
    endfunction

endpackage

// File: rtl/lpu_lane_map.sv
// Active-lane mask: a lane counts only when the transfer enables it
// and the lane lies inside the port width. Assumes lane 0 is the
// least significant byte and narrow ports use the low lanes.
module lpu_lane_map
    import lpu_pkg::*;
#(
    parameter int LANES = 4
) (
    input  port_size_e        port_size,
    input  logic [LANES-1:0]  rd_be,
    output logic [LANES-1:0]  active,
    output logic              full_port
);

    int unsigned span;

    // Work out how many lanes the port spans.
    always_comb begin
        span      = lanes_in_port(port_size, LANES);
        full_port = (span == LANES);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane is active if enabled and inside the port.
        always_comb active[i] = rd_be[i] && (i < span);
    end

endmodule

// File: rtl/lpu_wr_path.sv
// Write path: merges partial writes with the old word when the merge
// is enabled, then generates one parity bit per byte of the result.
// Assumes rd_data holds the old word whenever merging is requested.
module lpu_wr_path #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] old_data,
    input  logic              merge_en,
    input  logic              odd_par,
    output logic [DATA_W-1:0] merged,
    output logic [LANES-1:0]  par_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] byte_q;

        // Pick the new byte unless merging keeps the old one.
        always_comb begin
            if (merge_en && !wr_be[i]) byte_q = old_data[i*LANE_W +: LANE_W];
            else                       byte_q = wr_data[i*LANE_W +: LANE_W];
        end

        // Place the byte and its parity on the outputs.
        always_comb begin
            merged[i*LANE_W +: LANE_W] = byte_q;
            par_out[i]                 = (^byte_q) ^ odd_par;
        end
    end

endmodule

// File: rtl/lpu_rd_check.sv
// Read check: compares received parity lanes with parity recomputed
// from the read data and reports mismatches on enabled, active lanes.
// Assumes check_en already folds in the valid strobe and mode.
module lpu_rd_check #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic [LANES-1:0]  active,
    input  logic              check_en,
    input  logic              odd_par,
    output logic [LANES-1:0]  lane_bad
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic mismatch;

        // Ones count of byte plus parity bit must follow the sense.
        always_comb mismatch = (^rd_data[i*LANE_W +: LANE_W]) ^ rd_par[i] ^ odd_par;

        // Report only lanes in the transfer while checking.
        always_comb lane_bad[i] = check_en && active[i] && mismatch;
    end

endmodule

// File: rtl/lpu_err_bank.sv
// Sticky error registers with write-one-to-clear strobes.
// Assumes a set request and a clear in the same cycle resolve to set.
module lpu_err_bank #(
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_set,
    input  logic [LANES-1:0]  lane_clr,
    input  logic              cfg_set,
    input  logic              cfg_clr,
    output logic [LANES-1:0]  lane_err,
    output logic              cfg_err
);

    // Hold lane errors until cleared; new errors win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) lane_err <= '0;
        else        lane_err <= (lane_err & ~lane_clr) | lane_set;
    end

    // Same policy for the configuration error.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= (cfg_err & ~cfg_clr) | cfg_set;
    end

endmodule

// File: rtl/lane_parity_unit.sv
// Byte-lane parity generator and checker for a 32-bit bus.
// Drives write parity in every mode, checks reads in check mode and in
// read-modify-write mode on full-width ports, flags read-modify-write
// on narrow ports, and keeps sticky error flags.
// Assumes one access per cycle and that rd_data carries the old word
// during a read-modify-write merge.
module lane_parity_unit #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        par_mode,
    input  logic [1:0]        port_size,
    input  logic              odd_par,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic [LANES-1:0]  rd_be,
    input  logic              rd_valid,
    input  logic [LANES-1:0]  lane_clr,
    input  logic              cfg_clr,
    output logic [LANES-1:0]  wr_par,
    output logic [DATA_W-1:0] wr_merged,
    output logic [LANES-1:0]  lane_err,
    output logic              cfg_err,
    output logic              any_err
);
    import lpu_pkg::*;

    par_mode_e        mode;
    port_size_e       psize;
    logic [LANES-1:0] active;
    logic             full_port;
    logic             rmw_sel;
    logic             merge_en;
    logic             check_en;
    logic             cfg_set;
    logic [LANES-1:0] lane_bad;

    // Decode the mode into merge, check and misconfiguration controls.
    always_comb begin
        mode     = par_mode_e'(par_mode);
        psize    = port_size_e'(port_size);
        rmw_sel  = (mode == PM_RMW);
        merge_en = rmw_sel && full_port;
        check_en = rd_valid && ((mode == PM_CHECK) || merge_en);
        cfg_set  = rd_valid && rmw_sel && !full_port;
    end

    lpu_lane_map #(.LANES(LANES)) u_map (
        .port_size (psize),
        .rd_be     (rd_be),
        .active    (active),
        .full_port (full_port)
    );

    lpu_wr_path #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .old_data (rd_data),
        .merge_en (merge_en),
        .odd_par  (odd_par),
        .merged   (wr_merged),
        .par_out  (wr_par)
    );

    lpu_rd_check #(.LANES(LANES), .LANE_W(LANE_W)) u_chk_path (
        .rd_data  (rd_data),
        .rd_par   (rd_par),
        .active   (active),
        .check_en (check_en),
        .odd_par  (odd_par),
        .lane_bad (lane_bad)
    );

    lpu_err_bank #(.LANES(LANES)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_set (lane_bad),
        .lane_clr (lane_clr),
        .cfg_set  (cfg_set),
        .cfg_clr  (cfg_clr),
        .lane_err (lane_err),
        .cfg_err  (cfg_err)
    );

    // Summarise the lane errors.
    always_comb any_err = |lane_err;

endmodule

// File: rtl/lane_parity_unit_chk.sv
// Property checker for lane_parity_unit, attached by bind below.
// Assumes the default lane layout: lane i is bits i*LANE_W upward.
module lane_parity_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        par_mode,
    input logic [1:0]        port_size,
    input logic              odd_par,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic [DATA_W-1:0] rd_data,
    input logic [LANES-1:0]  rd_be,
    input logic              rd_valid,
    input logic [LANES-1:0]  lane_clr,
    input logic [LANES-1:0]  wr_par,
    input logic [DATA_W-1:0] wr_merged,
    input logic [LANES-1:0]  lane_err,
    input logic              cfg_err,
    input logic              any_err
);

    logic [LANES-1:0]  exp_full_par;
    logic [DATA_W-1:0] exp_rmw_word;
    logic [LANES-1:0]  port_mask;

    // Reference values built independently from the ports.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            exp_full_par[i] = (^wr_data[i*LANE_W +: LANE_W]) ^ odd_par;
            exp_rmw_word[i*LANE_W +: LANE_W] = wr_be[i] ? wr_data[i*LANE_W +: LANE_W]
                                                        : rd_data[i*LANE_W +: LANE_W];
            port_mask[i] = port_size[1] || (i == 0) || (port_size[0] && i == 1);
        end
    end

    assert_par_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be == {LANES{1'b1}}) |-> (wr_par == exp_full_par));

    assert_err_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_err) |-> $past(rd_valid));

    assert_off_mode_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (par_mode == 2'b00 || par_mode == 2'b11) && lane_clr == '0)
        |=> (lane_err == $past(lane_err)));

    assert_lanes_in_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_err & ~$past(lane_err)) & ~$past(rd_be & port_mask)) == '0);

    assert_rmw_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode == 2'b10 && port_size[1]) |-> (wr_merged == exp_rmw_word));

    assert_cfg_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(rd_valid && par_mode == 2'b10 && !port_size[1]));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lane_err & $past(lane_err & ~lane_clr)) == $past(lane_err & ~lane_clr)));

endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_prop_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_mode  (par_mode),
    .port_size (port_size),
    .odd_par   (odd_par),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .rd_data   (rd_data),
    .rd_be     (rd_be),
    .rd_valid  (rd_valid),
    .lane_clr  (lane_clr),
    .wr_par    (wr_par),
    .wr_merged (wr_merged),
    .lane_err  (lane_err),
    .cfg_err   (cfg_err),
    .any_err   (any_err)
);

// File: tb/lane_parity_unit_bench.sv
`timescale 1ns/1ps
module lane_parity_unit_bench;
    localparam int LANES = 4;
    localparam int LANE_W = 8;
    localparam int DW = LANES * LANE_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [1:0]    par_mode, port_size;
    logic          odd_par;
    logic [DW-1:0] wr_data, rd_data;
    logic [3:0]    wr_be, rd_par, rd_be, lane_clr;
    logic          rd_valid, cfg_clr;
    logic [3:0]    wr_par, lane_err;
    logic [DW-1:0] wr_merged;
    logic          cfg_err, any_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] m_lane = '0;
    logic       m_cfg = 1'b0;

    lane_parity_unit #(.LANES(LANES), .LANE_W(LANE_W)) u_lane_parity_unit (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .port_size(port_size),
        .odd_par(odd_par), .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data),
        .rd_par(rd_par), .rd_be(rd_be), .rd_valid(rd_valid), .lane_clr(lane_clr),
        .cfg_clr(cfg_clr), .wr_par(wr_par), .wr_merged(wr_merged),
        .lane_err(lane_err), .cfg_err(cfg_err), .any_err(any_err)
    );

    function automatic logic [3:0] f_par(input logic [DW-1:0] w, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (^w[i*8 +: 8]) ^ odd;
        return p;
    endfunction

    function automatic logic [3:0] f_mask(input logic [1:0] ps, input logic [3:0] be);
        logic [3:0] span;
        span = ps[1] ? 4'hF : (ps[0] ? 4'h3 : 4'h1);
        return be & span;
    endfunction

    function automatic logic [DW-1:0] f_merge(input logic [DW-1:0] w, input logic [DW-1:0] r,
                                              input logic [3:0] be, input logic [1:0] md,
                                              input logic [1:0] ps);
        logic [DW-1:0] m;
        m = w;
        if (md == 2'b10 && ps[1])
            for (int i = 0; i < 4; i++) if (!be[i]) m[i*8 +: 8] = r[i*8 +: 8];
        return m;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        par_mode = 2'b00; port_size = 2'b10; odd_par = 1'b0;
        wr_data = '0; wr_be = 4'hF; rd_data = '0; rd_par = '0; rd_be = 4'h0;
        rd_valid = 1'b0; lane_clr = '0; cfg_clr = 1'b0;
    endtask

    // Called at a falling edge with inputs set; checks the write path,
    // advances the model across one rising edge, checks the flags.
    task automatic step();
        logic [DW-1:0] mw;
        logic [3:0]    setm;
        logic          chk_mode, cfgset;
        #1;
        mw = f_merge(wr_data, rd_data, wr_be, par_mode, port_size);
        chk("R6 merged word", wr_merged, mw);
        chk("R1 drive parity", {28'd0, wr_par}, {28'd0, f_par(mw, odd_par)});
        chk_mode = (par_mode == 2'b01) || (par_mode == 2'b10 && port_size[1]);
        cfgset   = rd_valid && par_mode == 2'b10 && !port_size[1];
        setm     = (rd_valid && chk_mode) ? ((f_par(rd_data, odd_par) ^ rd_par) & f_mask(port_size, rd_be)) : 4'h0;
        m_lane   = (m_lane & ~lane_clr) | setm;
        m_cfg    = (m_cfg & ~cfg_clr) | cfgset;
        @(posedge clk);
        @(negedge clk);
        chk("R3 lane flags", {28'd0, lane_err}, {28'd0, m_lane});
        chk("R7 config flag", {31'd0, cfg_err}, {31'd0, m_cfg});
        chk("R9 aggregate flag", {31'd0, any_err}, {31'd0, |m_lane});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset lane_err", {28'd0, lane_err}, 32'd0);
        chk("R10 reset cfg_err", {31'd0, cfg_err}, 32'd0);
        chk("R10 reset any_err", {31'd0, any_err}, 32'd0);
        rst_n = 1'b1;

        // R2: known byte pattern under both senses.
        idle(); wr_data = 32'h0000_0103; #1;
        chk("R2 even parity", {28'd0, wr_par}, 32'h2);
        odd_par = 1'b1; #1;
        chk("R2 odd parity", {28'd0, wr_par}, 32'hD);
        @(negedge clk);

        // R4: reserved and off modes ignore corrupt parity.
        idle(); par_mode = 2'b11; rd_valid = 1'b1; rd_be = 4'hF; rd_data = 32'h1234_5678;
        rd_par = ~f_par(rd_data, 1'b0); step();
        chk("R4 reserved mode no error", {28'd0, lane_err}, 32'd0);
        par_mode = 2'b00; step();
        chk("R4 off mode no error", {28'd0, lane_err}, 32'd0);

        // R3: check mode, lane 2 corrupted.
        idle(); par_mode = 2'b01; rd_valid = 1'b1; rd_be = 4'hF; rd_data = 32'hDEAD_BEEF;
        rd_par = f_par(rd_data, 1'b0) ^ 4'b0100; step();
        chk("R3 lane 2 flagged", {28'd0, lane_err}, 32'h4);

        // R8: set and clear of lane 2 together keeps it, then clear alone.
        lane_clr = 4'b0100; step();
        chk("R8 set wins over clear", {28'd0, lane_err}, 32'h4);
        idle(); lane_clr = 4'hF; step();
        chk("R8 clear", {28'd0, lane_err}, 32'd0);

        // R5: 8-bit and 16-bit ports limit the checked lanes.
        idle(); par_mode = 2'b01; port_size = 2'b00; rd_valid = 1'b1; rd_be = 4'hF;
        rd_data = 32'h0F0F_0F0F; rd_par = ~f_par(rd_data, 1'b0); step();
        chk("R5 8-bit port lane 0 only", {28'd0, lane_err}, 32'h1);
        idle(); lane_clr = 4'hF; step();
        idle(); par_mode = 2'b01; port_size = 2'b01; rd_valid = 1'b1; rd_be = 4'b1110;
        rd_data = 32'h0F0F_0F0F; rd_par = ~f_par(rd_data, 1'b0); step();
        chk("R5 16-bit port lane 1 only", {28'd0, lane_err}, 32'h2);
        idle(); lane_clr = 4'hF; step();

        // R7: read-modify-write on a narrow port.
        idle(); par_mode = 2'b10; port_size = 2'b01; rd_valid = 1'b1; rd_be = 4'hF;
        rd_data = 32'h5555_AAAB; rd_par = ~f_par(rd_data, 1'b0); step();
        chk("R7 cfg_err set", {31'd0, cfg_err}, 32'd1);
        chk("R7 no lane check", {28'd0, lane_err}, 32'd0);
        idle(); cfg_clr = 1'b1; step();
        chk("R7 cfg_err cleared", {31'd0, cfg_err}, 32'd0);

        // R6: merge on a 32-bit port.
        idle(); par_mode = 2'b10; port_size = 2'b10; wr_be = 4'b0101;
        wr_data = 32'hAABB_CCDD; rd_data = 32'h1122_3344; rd_par = f_par(rd_data, 1'b0); #1;
        chk("R6 merged constant", wr_merged, 32'h11BB_33DD);
        step();

        // Random mix of all modes, sizes, senses and strobes.
        for (int n = 0; n < 600; n++) begin
            par_mode  = 2'($urandom_range(0, 3));
            port_size = 2'($urandom_range(0, 3));
            odd_par   = 1'($urandom_range(0, 1));
            wr_data   = $urandom;
            rd_data   = $urandom;
            wr_be     = 4'($urandom_range(0, 15));
            rd_be     = 4'($urandom_range(0, 15));
            rd_valid  = ($urandom_range(0, 3) != 0);
            rd_par    = f_par(rd_data, odd_par) ^ (($urandom_range(0, 1) != 0) ? 4'($urandom_range(0, 15)) : 4'h0);
            lane_clr  = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
            cfg_clr   = ($urandom_range(0, 5) == 0);
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule